// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block gathers a large set of peripheral interrupt request lines (96 by default) and presents them to a processor as a small set of CPU interrupt lines (12 by default). Each CPU line serves a group of eight sources. Every source has its own pending flag and its own enable bit. The flag latches on a rising edge of the request. Every source also has its own vector word in a small vector store that software can rewrite. When the processor acknowledges a line, the block selects the most urgent pending, enabled source of that group and clears its flag. After a fixed latency (nine clocks by default) it hands the processor that source's vector for one cycle.

Once a group has been acknowledged, its acknowledge bit gates the group's CPU line until software clears the bit. This lets the handler decide when the group may interrupt again. Software reaches the enables, flags, acknowledge bits and vectors through a single-cycle register port. Writes take effect on the clock edge. Reads are combinational.

The acknowledge path is a three-state machine:
- **IDLE** waits for any acknowledge bit. Transition *accept*: IDLE to FETCH.
- **FETCH** counts the latency. Transition *count*: FETCH to FETCH. Transition *expire*: FETCH to DELIVER.
- **DELIVER** drives the vector for one cycle. Transition *release*: DELIVER to IDLE.

Top module: `irq_group_expander`

## Requirements
- R1: A rising edge on `irq_req[n]` sets flag n whether or not source n is enabled. The flag of source `g*8+i` reads at register address `0x10+g`, bit i. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged.
- R2: `cpu_int[g]` is high exactly when some source of group g has both its flag and its enable set and the acknowledge bit of group g is clear. The enable of source `g*8+i` is bit i of read/write register `0x00+g`.
- R3: When an acknowledge is accepted for group g, the lowest-numbered source i of that group with flag and enable both set has its flag cleared. No other flag is cleared.
- R4: The accepting clock edge counts as edge 0. `vec_valid` is high only in the cycle after edge 9 (edge `ACK_LAT`), for exactly one cycle. `vec_data` then holds the vector of source `g*8+i` as it stood at the accepting edge.
- R5: The vector of source n is a `DATA_W`-bit read/write register at address `0x80+n`. All vectors reset to 0.
- R6: An accepted acknowledge of group g sets bit g of the acknowledge register at `0x20`, which blocks `cpu_int[g]`. Writing 1 to bit g clears it.
- R7: If several `cpu_ack` bits are high at acceptance, only the lowest-numbered group is served. The other groups' flags and acknowledge bits are untouched.
- R8: Acknowledges that arrive while the machine is in FETCH or DELIVER are ignored.
- R9: If the acknowledged group has no pending enabled source, `vec_data` delivers `SPUR_VEC` (0 by default). No flag is cleared, but the group's acknowledge bit is still set.
- R10: A rising request edge in the same cycle as a clear of that flag (by service or by software) leaves the flag set.
- R11: After reset, all flags, enables, acknowledge bits and `cpu_int` are 0, and `vec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_req | input | GROUPS*GROUP_W | Peripheral request lines, source n on bit n |
| cpu_int | output | GROUPS | CPU interrupt lines, bit 0 most urgent |
| cpu_ack | input | GROUPS | CPU acknowledge, one bit per line |
| vec_valid | output | 1 | One-cycle vector strobe |
| vec_data | output | DATA_W | Vector of the serviced source |

## Verification
The bench drives sparse random request bursts over all 96 sources, with random enable masks. These expose wrong gating of `cpu_int` by enables or acknowledge bits. Single and multiple simultaneous acknowledges over groups with zero, one and several pending sources tell apart the in-group priority, the lowest-group selection and the spurious-vector case. Directed cases inject an acknowledge during the wait, rewrite the pending vector during the wait, and make a rising edge coincide with a service clear or a software clear. These show whether a late input is wrongly sampled and whether set wins over clear.

// File: rtl/ige_pkg.sv
package ige_pkg;

    // acknowledge sequencer states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_DELIVER = 2'd2
    } ack_state_t;

    // register space kinds (low address space)
    localparam logic [1:0] KIND_ENABLE = 2'd0;
    localparam logic [1:0] KIND_FLAG   = 2'd1;
    localparam logic [1:0] KIND_ACK    = 2'd2;

endpackage

// File: rtl/ige_group.sv
module ige_group #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req,
    input  logic             en_we,
    input  logic [WIDTH-1:0] en_wdata,
    input  logic             flag_w1c,
    input  logic [WIDTH-1:0] flag_wdata,
    input  logic [WIDTH-1:0] svc_clr,
    input  logic             ack_set,
    input  logic             ack_clr,
    output logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] flag,
    output logic [WIDTH-1:0] pend,
    output logic             ack_bit,
    output logic             line
);

    logic [WIDTH-1:0] req_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] sw_clr;
    logic [WIDTH-1:0] flag_n;

    always_comb begin
        rise   = req & ~req_q;
        sw_clr = flag_w1c ? flag_wdata : '0;
        // a new edge wins over any clear in the same cycle
        flag_n = (flag & ~(svc_clr | sw_clr)) | rise;
        pend   = flag & en;
        line   = (|pend) & ~ack_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            flag    <= '0;
            en      <= '0;
            ack_bit <= 1'b0;
        end else begin
            req_q <= req;
            flag  <= flag_n;
            if (en_we) begin
                en <= en_wdata;
            end
            if (ack_set) begin
                ack_bit <= 1'b1;
            end else if (ack_clr) begin
                ack_bit <= 1'b0;
            end
        end
    end

    // R1 R10
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((flag & $past(rise)) == $past(rise)));

    // R3
    svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(svc_clr & ~rise & ~req_q)) |=> ((flag & $past(svc_clr & ~rise)) == '0));

    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_set |=> (ack_bit && !line));

endmodule

// File: rtl/ige_vec_store.sv
module ige_vec_store #(
    parameter int DEPTH  = 96,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  sw_raddr,
    output logic [DATA_W-1:0] sw_rdata,
    input  logic [IDX_W-1:0]  hw_raddr,
    output logic [DATA_W-1:0] hw_rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        sw_rdata = (int'(sw_raddr) < DEPTH) ? mem[sw_raddr] : '0;
        hw_rdata = (int'(hw_raddr) < DEPTH) ? mem[hw_raddr] : '0;
    end

endmodule

// File: rtl/ige_ack_ctrl.sv
module ige_ack_ctrl
    import ige_pkg::*;
#(
    parameter int              GROUPS   = 12,
    parameter int              GROUP_W  = 8,
    parameter int              DATA_W   = 16,
    parameter int              ACK_LAT  = 9,
    parameter logic [DATA_W-1:0] SPUR_VEC = '0,
    localparam int             NSRC     = GROUPS * GROUP_W,
    localparam int             IDX_W    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] cpu_ack,
    input  logic [NSRC-1:0]   pend_flat,
    output logic [IDX_W-1:0]  vec_raddr,
    input  logic [DATA_W-1:0] vec_rdata,
    output logic [GROUPS-1:0] ack_set,
    output logic [NSRC-1:0]   svc_clr,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_data
);

    localparam int GW = $clog2(GROUPS);
    localparam int SW = $clog2(GROUP_W);
    localparam int CW = $clog2(ACK_LAT + 2);

    ack_state_t        state, state_n;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] vec_hold;
    logic [GW-1:0]     grp;
    logic [SW-1:0]     src;
    logic [GROUP_W-1:0] grp_pend;
    logic              src_hit;
    logic              accept;

    function automatic logic [GW-1:0] first_grp(input logic [GROUPS-1:0] v);
        first_grp = '0;
        for (int k = GROUPS - 1; k >= 0; k--) begin
            if (v[k]) first_grp = GW'(k);
        end
    endfunction

    function automatic logic [SW-1:0] first_src(input logic [GROUP_W-1:0] v);
        first_src = '0;
        for (int k = GROUP_W - 1; k >= 0; k--) begin
            if (v[k]) first_src = SW'(k);
        end
    endfunction

    // selection of group and source
    always_comb begin
        grp       = first_grp(cpu_ack);
        grp_pend  = pend_flat[int'(grp) * GROUP_W +: GROUP_W];
        src_hit   = |grp_pend;
        src       = first_src(grp_pend);
        vec_raddr = IDX_W'(grp) * IDX_W'(GROUP_W) + IDX_W'(src);
        accept    = (state == ST_IDLE) && (|cpu_ack);
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (accept) state_n = ST_FETCH;
            ST_FETCH:   if (cnt == CW'(ACK_LAT)) state_n = ST_DELIVER;
            ST_DELIVER: state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // state register, latency counter and vector capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            vec_hold <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                cnt      <= CW'(1);
                vec_hold <= src_hit ? vec_rdata : SPUR_VEC;
            end else if (state == ST_FETCH) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        ack_set   = '0;
        svc_clr   = '0;
        vec_valid = 1'b0;
        vec_data  = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    ack_set[grp] = 1'b1;
                    if (src_hit) svc_clr = NSRC'(1) << vec_raddr;
                end
            end
            ST_FETCH: begin
                vec_valid = 1'b0;
            end
            ST_DELIVER: begin
                vec_valid = 1'b1;
                vec_data  = vec_hold;
            end
            default: begin
                vec_valid = 1'b0;
            end
        endcase
    end

    // independent age counter for the latency check
    logic [CW-1:0] chk_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_age <= '0;
        end else if (accept) begin
            chk_age <= CW'(1);
        end else if (chk_age != '0 && chk_age <= CW'(ACK_LAT)) begin
            chk_age <= chk_age + CW'(1);
        end else begin
            chk_age <= '0;
        end
    end

    // R4
    vec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (chk_age == CW'(ACK_LAT + 1)));

    // R4
    vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R7
    one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_set));

    // R3
    one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_clr));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (ack_set == '0 && svc_clr == '0));

endmodule

// File: rtl/irq_group_expander.sv
module irq_group_expander
    import ige_pkg::*;
#(
    parameter int                GROUPS   = 12,
    parameter int                GROUP_W  = 8,
    parameter int                DATA_W   = 16,
    parameter int                ADDR_W   = 8,
    parameter int                ACK_LAT  = 9,
    parameter logic [DATA_W-1:0] SPUR_VEC = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [GROUPS*GROUP_W-1:0]   irq_req,
    output logic [GROUPS-1:0]           cpu_int,
    input  logic [GROUPS-1:0]           cpu_ack,
    output logic                        vec_valid,
    output logic [DATA_W-1:0]           vec_data
);

    localparam int NSRC   = GROUPS * GROUP_W;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int GSEL_W = 4;

    // address decode
    logic             vec_space;
    logic             low_ok;
    logic [1:0]       kind;
    logic [GSEL_W-1:0] gsel;
    logic [IDX_W-1:0] vidx;
    logic             vidx_ok;

    always_comb begin
        vec_space = reg_addr[ADDR_W-1];
        low_ok    = !vec_space && (reg_addr[ADDR_W-2:6] == '0);
        kind      = reg_addr[5:4];
        gsel      = reg_addr[3:0];
        vidx      = reg_addr[IDX_W-1:0];
        vidx_ok   = vec_space && (int'(reg_addr[ADDR_W-2:0]) < NSRC);
    end

    logic [GROUP_W-1:0] en_all   [GROUPS];
    logic [GROUP_W-1:0] flag_all [GROUPS];
    logic [GROUPS-1:0]  ack_bits;
    logic [NSRC-1:0]    pend_flat;
    logic [NSRC-1:0]    svc_clr;
    logic [GROUPS-1:0]  ack_set;
    logic [IDX_W-1:0]   hw_raddr;
    logic [DATA_W-1:0]  hw_rdata;
    logic [DATA_W-1:0]  sw_rdata;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic               en_we;
        logic               flag_w1c;
        logic               ack_clr;
        logic [GROUP_W-1:0] pend;

        always_comb begin
            en_we    = reg_we && low_ok && (kind == KIND_ENABLE) && (gsel == GSEL_W'(g));
            flag_w1c = reg_we && low_ok && (kind == KIND_FLAG)   && (gsel == GSEL_W'(g));
            ack_clr  = reg_we && low_ok && (kind == KIND_ACK)    && (gsel == '0) && reg_wdata[g];
        end

        ige_group #(.WIDTH(GROUP_W)) u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (irq_req[g*GROUP_W +: GROUP_W]),
            .en_we      (en_we),
            .en_wdata   (reg_wdata[GROUP_W-1:0]),
            .flag_w1c   (flag_w1c),
            .flag_wdata (reg_wdata[GROUP_W-1:0]),
            .svc_clr    (svc_clr[g*GROUP_W +: GROUP_W]),
            .ack_set    (ack_set[g]),
            .ack_clr    (ack_clr),
            .en         (en_all[g]),
            .flag       (flag_all[g]),
            .pend       (pend),
            .ack_bit    (ack_bits[g]),
            .line       (cpu_int[g])
        );

        assign pend_flat[g*GROUP_W +: GROUP_W] = pend;
    end

    ige_vec_store #(
        .DEPTH  (NSRC),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we && vidx_ok),
        .waddr    (vidx),
        .wdata    (reg_wdata),
        .sw_raddr (vidx),
        .sw_rdata (sw_rdata),
        .hw_raddr (hw_raddr),
        .hw_rdata (hw_rdata)
    );

    ige_ack_ctrl #(
        .GROUPS   (GROUPS),
        .GROUP_W  (GROUP_W),
        .DATA_W   (DATA_W),
        .ACK_LAT  (ACK_LAT),
        .SPUR_VEC (SPUR_VEC)
    ) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_ack   (cpu_ack),
        .pend_flat (pend_flat),
        .vec_raddr (hw_raddr),
        .vec_rdata (hw_rdata),
        .ack_set   (ack_set),
        .svc_clr   (svc_clr),
        .vec_valid (vec_valid),
        .vec_data  (vec_data)
    );

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (vidx_ok) begin
            reg_rdata = sw_rdata;
        end else if (low_ok) begin
            case (kind)
                KIND_ENABLE: if (int'(gsel) < GROUPS) reg_rdata[GROUP_W-1:0] = en_all[gsel];
                KIND_FLAG:   if (int'(gsel) < GROUPS) reg_rdata[GROUP_W-1:0] = flag_all[gsel];
                KIND_ACK:    if (gsel == '0) reg_rdata[GROUPS-1:0] = ack_bits;
                default:     reg_rdata = '0;
            endcase
        end
    end

    // R2
    int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_bits & cpu_int) == '0));

    // R11
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpu_int == '0 && !vec_valid));

endmodule

// File: tb/sim_irq_group_expander.sv
`timescale 1ns/1ps
module sim_irq_group_expander;

    localparam int G = 12;
    localparam int W = 8;
    localparam int N = G * W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [N-1:0] irq_req = '0;
    logic [G-1:0] cpu_int;
    logic [G-1:0] cpu_ack = '0;
    logic        vec_valid;
    logic [15:0] vec_data;

    always #4 clk = ~clk;

    irq_group_expander u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .cpu_int(cpu_int), .cpu_ack(cpu_ack), .vec_valid(vec_valid), .vec_data(vec_data)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [N-1:0] m_en   = '0;
    logic [N-1:0] m_flag = '0;
    logic [G-1:0] m_ack  = '0;
    logic [15:0]  m_vec [N];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [G-1:0] exp_int();
        logic [G-1:0] e;
        for (int g = 0; g < G; g++)
            e[g] = (|(m_flag[g*W +: W] & m_en[g*W +: W])) && !m_ack[g];
        return e;
    endfunction

    task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_en(input int g, input logic [7:0] m);
        reg_wr(8'(g), {8'h0, m});
        m_en[g*W +: W] = m;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        irq_req = m;
        tick();
        m_flag |= m;
        irq_req = '0;
        tick();
    endtask

    task automatic check_flags(input string tag);
        logic [15:0] d;
        for (int g = 0; g < G; g++) begin
            reg_rd(8'h10 + 8'(g), d);
            check(tag, {16'h0, d}, {24'h0, m_flag[g*W +: W]});
        end
    endtask

    task automatic check_ack(input string tag);
        logic [15:0] d;
        reg_rd(8'h20, d);
        check(tag, {16'h0, d}, {20'h0, m_ack});
    endtask

    // acknowledge with optional same-edge requests, busy acknowledge and vector rewrite
    task automatic do_ack(input logic [G-1:0] lines, input logic [N-1:0] edge_req,
                          input logic [G-1:0] busy_lines, input bit rewrite);
        int g;
        int s;
        int tgt;
        logic [7:0]  p;
        logic [15:0] ev;
        g = 0;
        for (int k = G - 1; k >= 0; k--) if (lines[k]) g = k;
        p  = m_flag[g*W +: W] & m_en[g*W +: W];
        ev = 16'h0;
        s  = -1;
        for (int k = W - 1; k >= 0; k--) if (p[k]) s = k;
        if (s >= 0) begin
            ev = m_vec[g*W + s];
            m_flag[g*W + s] = 1'b0;
        end
        tgt = (s >= 0) ? g*W + s : g*W;
        m_ack[g] = 1'b1;
        m_flag |= edge_req;
        cpu_ack = lines;
        irq_req = edge_req;
        tick();
        cpu_ack = '0;
        irq_req = '0;
        for (int j = 1; j <= 8; j++) begin
            reg_we = 1'b0;
            if (j == 2 && rewrite) begin
                reg_addr = 8'h80 + 8'(tgt);
                reg_wdata = ~m_vec[tgt];
                reg_we = 1'b1;
                m_vec[tgt] = ~m_vec[tgt];
            end
            cpu_ack = (j == 3) ? busy_lines : '0;
            tick();
            reg_we = 1'b0;
            cpu_ack = '0;
        end
        check("R4 no early vector", {31'h0, vec_valid}, 32'h0);
        tick();
        check("R4 vector strobe at latency", {31'h0, vec_valid}, 32'h1);
        check("R4 R3 R9 vector value", {16'h0, vec_data}, {16'h0, ev});
        tick();
        check("R4 single cycle strobe", {31'h0, vec_valid}, 32'h0);
    endtask

    initial begin
        logic [15:0] d;
        void'($urandom(32'd1234));
        for (int k = 0; k < N; k++) m_vec[k] = '0;
        repeat (3) tick();
        check("R11 cpu_int after reset", {20'h0, cpu_int}, 32'h0);
        rst_n = 1'b1;
        tick();
        check("R11 cpu_int idle", {20'h0, cpu_int}, 32'h0);
        check("R11 vec_valid idle", {31'h0, vec_valid}, 32'h0);
        check_flags("R11 flags zero");
        check_ack("R11 ack zero");
        reg_rd(8'h85, d);
        check("R5 vector reset", {16'h0, d}, 32'h0);

        // R5 vector store
        for (int k = 0; k < N; k++) begin
            m_vec[k] = 16'($urandom);
            reg_wr(8'h80 + 8'(k), m_vec[k]);
        end
        reg_rd(8'h80 + 8'd37, d);
        check("R5 vector readback", {16'h0, d}, {16'h0, m_vec[37]});
        reg_rd(8'h80 + 8'd95, d);
        check("R5 vector readback top", {16'h0, d}, {16'h0, m_vec[95]});

        // R1 disabled source latches, no line
        pulse(N'(1) << 19);
        check("R1 disabled flag latches", {20'h0, cpu_int}, 32'h0);
        check_flags("R1 flag readback");
        set_en(2, 8'h08);
        check("R2 enable raises line", {20'h0, cpu_int}, {20'h0, exp_int()});

        // R3 priority within group: sources 5,3,6 of group 4
        set_en(4, 8'hFF);
        pulse((N'(1) << 37) | (N'(1) << 35) | (N'(1) << 38));
        do_ack(12'h010, '0, '0, 0);
        check_flags("R3 lowest flag cleared only");
        check("R6 ack blocks line", {20'h0, cpu_int}, {20'h0, exp_int()});
        check_ack("R6 ack bit set");
        reg_wr(8'h20, 16'h0010);
        m_ack[4] = 1'b0;
        check("R6 ack clear reopens line", {20'h0, cpu_int}, {20'h0, exp_int()});

        // R7 several acknowledges: groups 2 and 4 -> group 2
        do_ack(12'h014, '0, '0, 0);
        check_ack("R7 only lowest group acked");
        check_flags("R7 other group flags untouched");

        // R9 spurious acknowledge on empty group 9
        do_ack(12'h200, '0, '0, 0);
        check_ack("R9 ack bit set on empty group");

        // R8 busy acknowledge ignored, R4 rewrite during wait
        reg_wr(8'h20, 16'h0FFF);
        m_ack = '0;
        do_ack(12'h010, '0, 12'h001, 1);
        check_ack("R8 busy ack ignored");
        check_flags("R8 flags untouched by busy ack");

        // R10 rising edge with service clear: group 4 source 6 pending
        reg_wr(8'h20, 16'h0FFF);
        m_ack = '0;
        do_ack(12'h010, N'(1) << 38, '0, 0);
        check_flags("R10 edge beats service clear");

        // R10 rising edge with software clear
        irq_req = N'(1) << 38;
        reg_addr = 8'h14; reg_wdata = 16'h0040; reg_we = 1'b1;
        tick();
        reg_we = 1'b0; irq_req = '0;
        check_flags("R10 edge beats software clear");
        reg_wr(8'h14, 16'h0040);
        m_flag[38] = 1'b0;
        check_flags("R1 software clear");
        reg_wr(8'h14, 16'h0000);
        check_flags("R1 write zero keeps flags");

        // constrained random
        reg_wr(8'h20, 16'h0FFF);
        m_ack = '0;
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: pulse({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
                         & {$urandom, $urandom, $urandom});
                1: set_en(int'($urandom_range(0, G - 1)), 8'($urandom));
                2: begin
                    int g;
                    logic [7:0] m;
                    g = int'($urandom_range(0, G - 1));
                    m = 8'($urandom);
                    reg_wr(8'h10 + 8'(g), {8'h0, m});
                    m_flag[g*W +: W] &= ~m;
                end
                3: begin
                    logic [G-1:0] m;
                    m = 12'($urandom);
                    reg_wr(8'h20, {4'h0, m});
                    m_ack &= ~m;
                end
                4: begin
                    int k;
                    k = int'($urandom_range(0, N - 1));
                    m_vec[k] = 16'($urandom);
                    reg_wr(8'h80 + 8'(k), m_vec[k]);
                end
                default: begin
                    logic [G-1:0] l;
                    l = 12'(1 << $urandom_range(0, G - 1));
                    if ($urandom_range(0, 3) == 0) l |= 12'(1 << $urandom_range(0, G - 1));
                    do_ack(l, '0, '0, 0);
                    check_ack("R6 R7 random ack register");
                end
            endcase
            check("R2 random cpu_int", {20'h0, cpu_int}, {20'h0, exp_int()});
        end
        check_flags("R1 R3 random flags");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule